// File: doc/BRIEF.md
# Carry-Save Sequential Multiplier

This block multiplies two unsigned operands one multiplier bit per clock. The running partial product is never fully resolved while the loop runs. It is kept as two words, a sum word and a carry word. Each cycle, one row of full adders folds the gated multiplicand into those two words. So the per-cycle path is a single full-adder delay, whatever the operand width. The pair then shifts right by one place. The bit that falls out of the sum word becomes the next bit of the low product half.

After the last multiplier bit, the block spends one more cycle on a carry-propagate adder. That adder resolves the two words into the upper product half, and the full product is registered. A user pulses `start` with the operands present and waits for the one-cycle `done` pulse. The product then stays on `product` until the next result replaces it.

Top module: `csa_seq_mul`

## Requirements
- R1: While `rst` is high, and after its release until the first result, `done` is 0 and `product` is all zeros.
- R2: On each `done` pulse, `product` equals the unsigned product a·x of the operands captured at the accepted `start`, as a 2·W-bit value (default W = 8, so 16 bits; e.g. 101·172 = 17372, 255·255 = 65025, 0·x = 0).
- R3: `done` is high in exactly the cycle that follows the W+1-th rising edge after the edge that sampled an accepted `start`: W accumulate cycles plus one merge cycle.
- R4: `done` is a single-cycle pulse: it is never high on two consecutive cycles.
- R5: A `start` sampled while an operation is in progress has no effect: the result and its timing stay those of the first operation, and no extra `done` appears.
- R6: The operands are captured only on the edge that accepts `start`; changing `a` or `x` afterwards does not change the result.
- R7: `product` changes only on the edge that raises `done`, and holds its value in every other cycle.
- R8: A `start` sampled in the cycle in which `done` is high is accepted, so operations may run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication with the current `a` and `x` when idle |
| a | input | W | Multiplicand, unsigned |
| x | input | W | Multiplier, unsigned |
| done | output | 1 | One-cycle pulse when `product` carries a new result |
| product | output | 2·W | Registered unsigned product |

## Verification
The checker keeps its own model of when a request is in flight. It assumes `start` is only meaningful when the block is idle or in its `done` cycle. It also assumes the operands that count are those present on the accepting edge. The stimulus respects this by driving every input at the falling edge. It repeats `start` during a run only in the deliberate overlap case, and there it expects no extra result. Operand values cover zero, one, all ones, single high bits and a random spread, so every carry-save bit position sees both zero and one terms.

// File: rtl/csa_mul_pkg.sv
package csa_mul_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ACCUM = 2'd1,
      ST_MERGE = 2'd2
   } mul_state_t;
endpackage

// File: rtl/csa_mul_fa.sv
module csa_mul_fa (
   input  logic x0,
   input  logic x1,
   input  logic x2,
   output logic sum,
   output logic cy
);
   assign sum = x0 ^ x1 ^ x2;
   assign cy  = (x0 & x1) | (x0 & x2) | (x1 & x2);
endmodule

// File: rtl/csa_mul_row.sv
// One carry-save row: three W-bit words in, sum and carry words out.
// Carry bit i carries weight i+1.
module csa_mul_row #(
   parameter int W = 8
) (
   input  logic [W-1:0] in_s,
   input  logic [W-1:0] in_c,
   input  logic [W-1:0] in_t,
   output logic [W-1:0] out_s,
   output logic [W-1:0] out_c
);
   for (genvar i = 0; i < W; i++) begin : g_col
      csa_mul_fa u_fa (
         .x0  (in_s[i]),
         .x1  (in_c[i]),
         .x2  (in_t[i]),
         .sum (out_s[i]),
         .cy  (out_c[i])
      );
   end
endmodule

// File: rtl/csa_mul_cpa.sv
// Final merge adder. RIPPLE=1 builds an explicit full-adder chain,
// RIPPLE=0 leaves the adder structure to the tools.
module csa_mul_cpa #(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   output logic [W-1:0] res
);
   if (RIPPLE) begin : g_ripple
      logic [W-1:0] chain;
      assign chain[0] = 1'b0;
      for (genvar i = 0; i < W-1; i++) begin : g_bit
         csa_mul_fa u_fa (
            .x0  (op_a[i]),
            .x1  (op_b[i]),
            .x2  (chain[i]),
            .sum (res[i]),
            .cy  (chain[i+1])
         );
      end
      assign res[W-1] = op_a[W-1] ^ op_b[W-1] ^ chain[W-1];
   end else begin : g_behav
      assign res = op_a + op_b;
   end
endmodule

// File: rtl/csa_mul_ctrl.sv
module csa_mul_ctrl
   import csa_mul_pkg::*;
#(
   parameter int W = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic load,
   output logic step,
   output logic merge
);
   localparam int CW = (W > 2) ? $clog2(W) : 1;
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   mul_state_t    state_q, state_d;
   logic [CW-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      load    = 1'b0;
      step    = 1'b0;
      merge   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               load    = 1'b1;
               cnt_d   = '0;
               state_d = ST_ACCUM;
            end
         end
         ST_ACCUM: begin
            step = 1'b1;
            if (cnt_q == LAST) begin
               state_d = ST_MERGE;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_MERGE: begin
            merge   = 1'b1;
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end
endmodule

// File: rtl/csa_seq_mul.sv
module csa_seq_mul #(
   parameter int W          = 8,
   parameter bit RIPPLE_CPA = 1'b1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           start,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   x,
   output logic           done,
   output logic [2*W-1:0] product
);
   localparam int PW = 2 * W;

   if (W < 2) begin : g_bad_width
      $error("csa_seq_mul: W must be at least 2");
   end

   logic           load, step, merge;
   logic [W-1:0]   a_q, x_q, s_q, c_q, lo_q;
   logic [W-1:0]   term, s_new, c_new, hi_sum;
   logic [PW-1:0]  prod_q;
   logic           done_q;

   csa_mul_ctrl #(.W(W)) u_ctrl (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .load  (load),
      .step  (step),
      .merge (merge)
   );

   assign term = a_q & {W{x_q[0]}};

   csa_mul_row #(.W(W)) u_row (
      .in_s  (s_q),
      .in_c  (c_q),
      .in_t  (term),
      .out_s (s_new),
      .out_c (c_new)
   );

   csa_mul_cpa #(.W(W), .RIPPLE(RIPPLE_CPA)) u_cpa (
      .op_a (s_q),
      .op_b (c_q),
      .res  (hi_sum)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q    <= '0;
         x_q    <= '0;
         s_q    <= '0;
         c_q    <= '0;
         lo_q   <= '0;
         prod_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= merge;
         if (load) begin
            a_q  <= a;
            x_q  <= x;
            s_q  <= '0;
            c_q  <= '0;
            lo_q <= '0;
         end
         if (step) begin
            // sum bit 0 retires; carry bits already sit one place up
            lo_q <= {s_new[0], lo_q[W-1:1]};
            s_q  <= {1'b0, s_new[W-1:1]};
            c_q  <= c_new;
            x_q  <= {1'b0, x_q[W-1:1]};
         end
         if (merge) begin
            prod_q <= {hi_sum, lo_q};
         end
      end
   end

   assign done    = done_q;
   assign product = prod_q;
endmodule

// File: rtl/csa_mul_chk.sv
module csa_mul_chk #(
   parameter int W = 8
) (
   input logic           clk,
   input logic           rst,
   input logic           start,
   input logic [W-1:0]   a,
   input logic [W-1:0]   x,
   input logic           done,
   input logic [2*W-1:0] product
);
   localparam int PW = 2 * W;
   localparam int KW = $clog2(W + 3) + 1;
   localparam logic [KW-1:0] FIN = KW'(W + 1);

   logic          busy_m;
   logic [KW-1:0] cnt_m;
   logic [PW-1:0] exp_m;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_m <= 1'b0;
         cnt_m  <= '0;
         exp_m  <= '0;
      end else if ((!busy_m || done) && start) begin
         busy_m <= 1'b1;
         cnt_m  <= '0;
         exp_m  <= {{W{1'b0}}, a} * {{W{1'b0}}, x};
      end else if (done) begin
         busy_m <= 1'b0;
      end else if (busy_m) begin
         cnt_m <= cnt_m + 1'b1;
      end
   end

   // R2, and R5/R6 through the model's capture rule
   p_product_r2: assert property (@(posedge clk) disable iff (rst)
      done |-> product == exp_m);
   p_latency_r3: assert property (@(posedge clk) disable iff (rst)
      (busy_m && cnt_m == FIN) |-> done);
   p_no_early_r3: assert property (@(posedge clk) disable iff (rst)
      done |-> (busy_m && cnt_m == FIN));
   p_pulse_r4: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !done |-> $stable(product));
endmodule

bind csa_seq_mul csa_mul_chk #(.W(W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .start   (start),
   .a       (a),
   .x       (x),
   .done    (done),
   .product (product)
);

// File: tb/csa_seq_mul_test.sv
`timescale 1ns/1ps
module csa_seq_mul_test;
   localparam int W = 8;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           start = 1'b0;
   logic [W-1:0]   a_i = '0;
   logic [W-1:0]   x_i = '0;
   logic           done;
   logic [2*W-1:0] product;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   int exp_q[$];
   longint t_q[$];
   bit done_prev = 1'b0;

   always #5 clk = ~clk;

   csa_seq_mul #(.W(W)) uut (
      .clk(clk), .rst(rst), .start(start), .a(a_i), .x(x_i),
      .done(done), .product(product)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // driver: called at a falling edge, pushes the expectation and pulses start
   task automatic issue(input int av, input int xv);
      a_i   = W'(av);
      x_i   = W'(xv);
      start = 1'b1;
      exp_q.push_back(av * xv);
      t_q.push_back($time);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (!rst) begin
         if (done_prev)   // R4
            check(!done, "R4 done width", done, 0);
         if (done) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R5 unexpected done", 1, 0);
            end else begin
               int e;
               longint t0;
               e  = exp_q.pop_front();
               t0 = t_q.pop_front();
               check(product == 16'(e), "R2 product", product, e);
               check(($time - t0) == 10 * (W + 2), "R3 latency ns", $time - t0, 10 * (W + 2));
            end
         end
      end
      done_prev = done;
   end

   initial begin
      #2_000_000;
      if (!finished) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog actual=timeout expected=finish");
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [2*W-1:0] held;
      repeat (3) @(negedge clk);
      check(!done, "R1 done in reset", done, 0);
      check(product == 0, "R1 product in reset", product, 0);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      check(!done, "R1 done after reset", done, 0);
      check(product == 0, "R1 product after reset", product, 0);

      // corner operands, R2
      issue(101, 172); wait_done();
      issue(0, 77);    wait_done();
      issue(200, 0);   wait_done();
      issue(255, 255); wait_done();
      issue(1, 255);   wait_done();
      issue(255, 1);   wait_done();
      issue(128, 128); wait_done();
      issue(85, 170);  wait_done();

      // R5 and R6: operand changes and a repeated start during the run
      @(negedge clk);
      issue(101, 172);
      a_i = 8'd3; x_i = 8'd5;
      repeat (3) @(negedge clk);
      start = 1'b1; a_i = 8'd7; x_i = 8'd9;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      @(negedge clk);
      repeat (12) @(negedge clk);
      check(exp_q.size() == 0, "R5 queue drained", exp_q.size(), 0);

      // R7: product holds while idle with moving inputs
      held = product;
      repeat (6) begin
         a_i = a_i + 8'd13; x_i = x_i + 8'd7;
         @(negedge clk);
      end
      check(product == held, "R7 product hold", product, held);
      check(!done, "R5 no spurious done", done, 0);

      // R8: back-to-back random operations (each issue starts in the done cycle)
      @(negedge clk);
      for (int k = 0; k < 300; k++) begin
         issue(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
         wait_done();
      end
      repeat (12) @(negedge clk);
      check(exp_q.size() == 0, "R8 all results seen", exp_q.size(), 0);

      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule